// File: doc/BRIEF.md
# Sixteen-to-one serializer with phased word clock

The block turns a 16-bit parallel word into a serial bit stream that runs at sixteen times the word rate. A free-running divide-by-16 counter on the bit clock sets the word boundaries. At each boundary the counter makes a one-cycle load pulse that captures the parallel input into a shift register. The shift register then sends the word out with bit 0 first. The serial bit passes through one last register on the bit clock before it leaves the block.

The same counter makes a word-rate clock with a 50% duty cycle, which is returned to the upstream logic. The upstream logic launches each new word from that clock. A 2-bit select moves the word clock in quarter-period steps of four bit periods, so that its edge can be placed where the upstream round trip needs it. The select is read only at a word boundary. Moving the word clock therefore never shortens a level below a quarter period, and it never moves the word boundaries of the serial stream.

Top module: `ser16_phased`

## Requirements
- R1: After the first word has been captured, every word is sent as 16 consecutive serial bits, and the next captured word follows with no gap or overlap.
- R2: Within a word, the serial order is par_in bit 0 first, then bit 1, up to bit 15 last.
- R3: A word is captured on the load edge. Its bit 0 appears on ser_out after the next rising edge of the bit clock, which is the one retime register of latency.
- R4: A load (capture) edge occurs every 16 bit-clock cycles. The first load edge is the 16th rising edge after reset is released.
- R5: While the select is steady, word_clk has a period of 16 bit clocks and is high for 8 cycles and low for 8 cycles.
- R6: The select decodes as {phase_sel[1], phase_sel[0]}: 00 is 0 degrees, 10 is 90, 01 is 180 and 11 is 270. At 0 degrees word_clk goes high on the capture edge. Each step of 90 degrees moves the rising edge of word_clk 4 bit clocks later.
- R7: phase_sel is sampled only on the capture edge. A change between capture edges has no effect on word_clk until the next capture edge.
- R8: Across any phase change, every high and every low level of word_clk lasts at least 4 bit-clock cycles.
- R9: Changing phase_sel does not move the capture edge or change the serial stream.
- R10: During and after synchronous reset (rst high), ser_out is 0 and word_clk is 1. ser_out stays 0 until the first captured word starts to shift out, and the phase is 0 degrees until the first capture edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate bit clock |
| rst | input | 1 | Synchronous reset, active high |
| par_in | input | 16 | Parallel word, bit 0 is sent first |
| phase_sel | input | 2 | Word clock phase select, bit 1 is the first select |
| ser_out | output | 1 | Retimed serial bit stream |
| word_clk | output | 1 | Word-rate clock returned to the upstream logic |

## Verification
Single-bit words such as 0x0001 and 0x8000 show whether the stream starts at bit 0 or at bit 15, and whether the retime latency is off by a cycle. Asymmetric words, and words that change on every cycle, show whether capture happens on exactly one edge per word. A word of all ones held through reset shows that ser_out stays low until the first real word shifts out. Each select value held for several words fixes the offset and duty cycle for that code. A select toggled every three cycles shows any sampling away from the word boundary, any level shorter than a quarter period, and any disturbance of the serial stream.

// File: rtl/ser_pkg.sv
package ser_pkg;

    typedef enum logic [1:0] {
        PH_0   = 2'd0,
        PH_90  = 2'd1,
        PH_180 = 2'd2,
        PH_270 = 2'd3
    } phase_e;

    // Non-binary select code: sel[1] is the first select, sel[0] the second
    function automatic phase_e decode_sel(input logic [1:0] sel);
        phase_e p;
        case (sel)
            2'b00:   p = PH_0;
            2'b10:   p = PH_90;
            2'b01:   p = PH_180;
            default: p = PH_270;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/ser_div.sv
module ser_div #(
    parameter int W = 16,
    localparam int CW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] cnt_nx_o,
    output logic          load_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CW'(W - 1)) st_d.cnt = '0;
        else                        st_d.cnt = st_q.cnt + 1'b1;
        if (rst) st_d.cnt = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign load_o   = (st_q.cnt == CW'(W - 1)) && !rst;
    assign cnt_nx_o = st_d.cnt;

    // R4
    load_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        load_o |=> (st_q.cnt == '0));

endmodule

// File: rtl/ser_wclk.sv
module ser_wclk
    import ser_pkg::*;
#(
    parameter int W = 16,
    localparam int CW = $clog2(W),
    localparam int QUARTER = W / 4,
    localparam int HALF = W / 2,
    localparam int RW = $clog2(QUARTER + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [CW-1:0] cnt_nx_i,
    input  logic [1:0]    sel_i,
    output logic          wclk_o
);

    typedef struct packed {
        phase_e        ph;
        logic          wclk;
        logic [RW-1:0] run;
    } wc_t;

    wc_t st_d, st_q;
    int  pos;

    always_comb begin
        st_d = st_q;
        if (load_i) st_d.ph = decode_sel(sel_i);
        pos = int'(cnt_nx_i) + W - QUARTER * int'(st_d.ph);
        if (pos >= W) pos = pos - W;
        st_d.wclk = (pos < HALF);
        if (st_d.wclk != st_q.wclk)        st_d.run = '0;
        else if (st_q.run != RW'(QUARTER)) st_d.run = st_q.run + 1'b1;
        if (rst) begin
            st_d.ph   = PH_0;
            st_d.wclk = 1'b1;
            st_d.run  = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign wclk_o = st_q.wclk;

    // R8
    min_level_chk: assert property (@(posedge clk) disable iff (rst)
        (st_d.wclk != st_q.wclk) |-> (st_q.run >= RW'(QUARTER - 1)));

    // R7
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(st_q.ph));

endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] din_i,
    output logic         ser_o
);

    typedef struct packed {
        logic [W-1:0] sh;
        logic         ser;
    } sh_t;

    sh_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ser = st_q.sh[0];
        if (load_i) st_d.sh = din_i;
        else        st_d.sh = st_q.sh >> 1;
        if (rst) begin
            st_d.sh  = '0;
            st_d.ser = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ser_o = st_q.ser;

    // R3
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (st_q.sh == $past(din_i)));

endmodule

// File: rtl/ser16_phased.sv
module ser16_phased #(
    parameter int W = 16,
    localparam int CW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] par_in,
    input  logic [1:0]   phase_sel,
    output logic         ser_out,
    output logic         word_clk
);

    logic [CW-1:0] cnt_nx;
    logic          load;

    ser_div #(.W(W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .cnt_nx_o (cnt_nx),
        .load_o   (load)
    );

    ser_wclk #(.W(W)) u_wclk (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .cnt_nx_i (cnt_nx),
        .sel_i    (phase_sel),
        .wclk_o   (word_clk)
    );

    ser_shift #(.W(W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .din_i  (par_in),
        .ser_o  (ser_out)
    );

    // R2
    first_bit_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> ##2 (ser_out == $past(par_in[0], 2)));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!ser_out && word_clk));

endmodule

// File: tb/tb_ser16_phased.sv
module tb_ser16_phased;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] par_in = 16'hFFFF;
    logic [1:0]  phase_sel = 2'b00;
    logic        ser_out, word_clk;

    int    tests = 0;
    int    fails = 0;
    bit    done = 1'b0;
    bit    checking = 1'b0;
    string ser_tag = "R10";
    string wclk_tag = "R10";

    // model state
    int   m_cnt = 0;
    int   m_ph = 0;
    bit   bitq[$];
    logic exp_ser = 1'b0;
    logic exp_wclk = 1'b1;
    int   run_len = 1;
    logic prev_w = 1'b1;

    always #5 clk = ~clk;

    ser16_phased dut (
        .clk       (clk),
        .rst       (rst),
        .par_in    (par_in),
        .phase_sel (phase_sel),
        .ser_out   (ser_out),
        .word_clk  (word_clk)
    );

    // R6 table: {sel[1], sel[0]} 00->0, 10->1, 01->2, 11->3 quarter steps
    function automatic int phase_steps(input logic [1:0] s);
        if (s == 2'b00) return 0;
        if (s == 2'b10) return 1;
        if (s == 2'b01) return 2;
        return 3;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at %0t: actual %0b expected %0b",
                     tag, what, $time, act, exp);
        end
    endtask

    // reference model: the bit stream is a queue, the phase is an integer offset
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0;
            m_ph  = 0;
            bitq.delete();
            exp_ser  = 1'b0;
            exp_wclk = 1'b1;
        end else begin
            if (bitq.size() > 0) exp_ser = bitq.pop_front();
            else                 exp_ser = 1'b0;
            if (m_cnt == 15) begin
                for (int i = 0; i < 16; i++) bitq.push_back(par_in[i]);
                m_ph = phase_steps(phase_sel);
            end
            m_cnt = (m_cnt + 1) % 16;
            exp_wclk = (((m_cnt - 4 * m_ph + 16) % 16) < 8);
        end
        checking = 1'b1;
    end

    always @(negedge clk) begin
        if (checking) begin
            check(ser_tag, "ser_out", ser_out, exp_ser);
            check(wclk_tag, "word_clk", word_clk, exp_wclk);
            if (rst) begin
                run_len = 1;
                prev_w  = word_clk;
            end else if (word_clk !== prev_w) begin
                // R8: each level lasts at least four bit clocks
                tests++;
                if (run_len < 4) begin
                    fails++;
                    $display("FAIL R8 word_clk level width: actual %0d expected >= 4",
                             run_len);
                end
                run_len = 1;
                prev_w  = word_clk;
            end else begin
                run_len++;
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R10: reset state, word of all ones waiting at the input
        cycles(3);
        rst = 1'b0;
        // R4 / R10: first capture at the 16th edge, ser_out low before it
        ser_tag  = "R4/R10";
        wclk_tag = "R5";
        cycles(40);

        // R1 / R2 / R3: single-bit and asymmetric words
        ser_tag = "R1/R2/R3";
        par_in = 16'h0001; cycles(16);
        par_in = 16'h8000; cycles(16);
        par_in = 16'hA5C3; cycles(16);
        par_in = 16'h1234; cycles(16);
        par_in = 16'h0000; cycles(16);
        par_in = 16'hFFFF; cycles(16);
        for (int i = 0; i < 64; i++) begin
            par_in = 16'($urandom);
            cycles(1);
        end

        // R5 / R6: each select code held for several words
        wclk_tag = "R5/R6";
        phase_sel = 2'b00; cycles(48);
        phase_sel = 2'b10; cycles(48);
        phase_sel = 2'b01; cycles(48);
        phase_sel = 2'b11; cycles(48);
        phase_sel = 2'b00; cycles(48);

        // R7 / R8 / R9: select toggled in mid-word
        wclk_tag = "R7/R8";
        ser_tag  = "R9";
        for (int i = 0; i < 60; i++) begin
            phase_sel = 2'($urandom);
            par_in    = 16'($urandom);
            cycles(3);
        end

        // R10: reset again in mid-stream
        ser_tag  = "R10";
        wclk_tag = "R10";
        rst = 1'b1;
        cycles(2);
        rst = 1'b0;
        par_in = 16'h00F0;
        cycles(40);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule